// File: doc/BRIEF.md
# Fractional-N Accumulator-Controlled Clock Divider

This block divides a fast input clock, which stands in for the oscillator of a frequency synthesizer, and emits one single-cycle pulse at the end of every division cycle. Each division cycle lasts either N or N+1 input clocks. The choice is made by a first-order phase accumulator of width `K_W`. Once per division cycle the accumulator adds a programmable fraction word K, and the carry out of that addition selects the longer modulus for the cycle that follows. Over many cycles the mean division ratio becomes N + K/2^K_W, so the pulse train runs at a non-integer fraction of the input clock.

The integer word N is programmable, so a set of channels can be reached. Values below 2 are raised to 2. New N and K values are taken only at the boundary between division cycles, so a count in progress is never cut short or stretched. An enable freezes all activity, and a synchronous reset returns the accumulator, the modulus bit and the counter to their starting state. The first cycle after reset divides by N.

Top module: `frac_n_div`

## Requirements
- R1: `pulse_o` is high for exactly one input clock at the last clock of each division cycle, and that clock is always followed by a low clock.
- R2: At each division-cycle boundary `acc_o` becomes (`acc_o` + `k_frac`) mod 2^K_W, and it holds its value between boundaries.
- R3: When the addition in R2 carries out of bit K_W-1, the next division cycle lasts `n_int`+1 enabled clocks and `mod_sel_o` is 1 throughout it. Otherwise the cycle lasts `n_int` clocks and `mod_sel_o` is 0.
- R4: Over 2^K_W consecutive division cycles that start at accumulator value 0, exactly K cycles are long, where K is the value of `k_frac`.
- R5: A value of `n_int` below 2 (0 or 1) divides as if it were 2.
- R6: A change of `n_int` or `k_frac` in the middle of a division cycle does not alter that cycle. The value present at the closing boundary sets the next cycle's length and the accumulator update.
- R7: While `rst` is high at a clock edge, `acc_o` and `mod_sel_o` become 0 and `pulse_o` stays 0. The first division cycle after release lasts `n_int` clocks.
- R8: With `k_frac` = 0, every cycle lasts exactly `n_int` clocks and `mod_sel_o` stays 0.
- R9: While `en` is low, `pulse_o` stays 0, `acc_o` and `mod_sel_o` hold, and the count pauses. It resumes where it stopped once `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the divider |
| n_int | input | N_W | Integer divide word N (minimum effective value 2) |
| k_frac | input | K_W | Fraction word added to the accumulator each division cycle |
| pulse_o | output | 1 | One-clock pulse ending each division cycle |
| mod_sel_o | output | 1 | Modulus bit of the current cycle (1 = divide by N+1) |
| acc_o | output | K_W | Phase accumulator contents |

## Verification
The assertions assume that `rst` is high at the first clock edge, and that `en`, `n_int` and `k_frac` change only between clock edges and never on the edge itself. The bench changes every input one nanosecond after a rising edge and holds reset for several clocks at the start. Its reference model samples `n_int` and `k_frac` on the falling edge of each pulse clock, which is the value the closing boundary uses. This lets it accept changes at any point in a cycle, including in mid-count.

// File: rtl/frac_n_div.sv
module frac_n_div #(
  parameter int N_W = 16,
  parameter int K_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [N_W-1:0] n_int,
  input  logic [K_W-1:0] k_frac,
  output logic           pulse_o,
  output logic           mod_sel_o,
  output logic [K_W-1:0] acc_o
);
  localparam logic [N_W-1:0] N_MIN = N_W'(2);
  localparam logic [N_W-1:0] ONE   = N_W'(1);

  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] n_eff;
  logic [K_W:0]   sum;

  assign n_eff   = (n_int < N_MIN) ? N_MIN : n_int;
  assign sum     = {1'b0, acc_o} + {1'b0, k_frac};
  assign pulse_o = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= n_eff - ONE;
      acc_o     <= '0;
      mod_sel_o <= 1'b0;
    end else if (pulse_o) begin
      cnt_q     <= n_eff - ONE + N_W'(sum[K_W]);
      acc_o     <= sum[K_W-1:0];
      mod_sel_o <= sum[K_W];
    end else if (en) begin
      cnt_q     <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/frac_n_div_chk.sv
module frac_n_div_chk #(
  parameter int K_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [K_W-1:0] k_frac,
  input logic           pulse_o,
  input logic           mod_sel_o,
  input logic [K_W-1:0] acc_o
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  a_r9_pulse_needs_en: assert property (@(posedge clk) disable iff (rst)
    !en |-> !pulse_o);

  a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> {mod_sel_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(k_frac)}));

  a_r2_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |=> $stable(acc_o));

  a_r6_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !pulse_o |=> $stable(mod_sel_o));

  a_r8_no_long_at_zero: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && k_frac == '0) |=> !mod_sel_o);

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && !mod_sel_o && !pulse_o));
endmodule

bind frac_n_div frac_n_div_chk #(.K_W(K_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .k_frac(k_frac),
  .pulse_o(pulse_o), .mod_sel_o(mod_sel_o), .acc_o(acc_o)
);

// File: tb/frac_n_div_tb_top.sv
`timescale 1ns/1ps
module frac_n_div_tb_top;
  localparam int N_W = 16;
  localparam int K_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic [N_W-1:0] n_r = 16'd5;
  logic [K_W-1:0] k_r = '0;
  logic pulse_o, mod_sel_o;
  logic [K_W-1:0] acc_o;

  int checks = 0;
  int fails = 0;
  int long_cnt = 0;
  int per_cnt = 0;
  bit st_pend = 0;
  logic [K_W-1:0] acc_m = '0;
  int q_per[$];
  logic [K_W:0] q_st[$];
  string tag = "R7";

  frac_n_div #(.N_W(N_W), .K_W(K_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .n_int(n_r), .k_frac(k_r),
    .pulse_o(pulse_o), .mod_sel_o(mod_sel_o), .acc_o(acc_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int neff(logic [N_W-1:0] n);
    return (n < 2) ? 2 : int'(n);
  endfunction

  // monitor and reference model
  always @(negedge clk) begin
    if (rst) begin
      acc_m = '0;
      q_per.delete();
      q_st.delete();
      per_cnt = 0;
      st_pend = 0;
      q_per.push_back(neff(n_r));
    end else begin
      if (st_pend) begin
        logic [K_W:0] e;
        st_pend = 0;
        e = q_st.pop_front();
        chk({mod_sel_o, acc_o} == e, "R2", {mod_sel_o, acc_o}, e);
        chk(pulse_o == 1'b0, "R1", pulse_o, 0);
      end
      if (en) per_cnt++;
      if (pulse_o) begin
        logic [K_W:0] s;
        int ep;
        ep = (q_per.size() > 0) ? q_per.pop_front() : -1;
        chk(per_cnt == ep, tag, per_cnt, ep);
        long_cnt += int'(mod_sel_o);
        per_cnt = 0;
        s = {1'b0, acc_m} + {1'b0, k_r};
        acc_m = s[K_W-1:0];
        q_st.push_back(s);
        q_per.push_back(neff(n_r) + int'(s[K_W]));
        st_pend = 1;
      end
    end
  end

  task automatic go(int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (pulse_o && !rst) seen++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc_o == '0, "R7", acc_o, 0);
    chk(mod_sel_o == 1'b0, "R7", mod_sel_o, 0);
    chk(pulse_o == 1'b0, "R7", pulse_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R7 reset state, then R8 plain divide
    n_r = 16'd5; k_r = '0;
    do_reset();
    tag = "R8";
    long_cnt = 0;
    go(8);
    chk(long_cnt == 0, "R8", long_cnt, 0);

    // R3 fractional operation
    tag = "R3";
    n_r = 16'd7; k_r = 6'd21;
    go(30);

    // R4 window of 2^K_W cycles from accumulator zero
    tag = "R4";
    do_reset();
    go(1);
    long_cnt = 0;
    go(64);
    chk(long_cnt == 21, "R4", long_cnt, 21);

    // R5 clamp of small N
    tag = "R5";
    n_r = 16'd1; k_r = 6'd13;
    go(10);
    n_r = 16'd0;
    go(10);

    // R6 mid-cycle change
    tag = "R6";
    n_r = 16'd6; k_r = 6'd40;
    go(3);
    repeat (2) @(posedge clk);
    #1;
    n_r = 16'd9; k_r = 6'd50;
    go(12);

    // R9 enable low freezes everything
    begin
      logic [K_W-1:0] a0;
      logic s0;
      @(posedge clk); #1;
      en = 1'b0;
      @(negedge clk);
      a0 = acc_o; s0 = mod_sel_o;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(pulse_o == 1'b0, "R9", pulse_o, 0);
        chk(acc_o == a0, "R9", acc_o, a0);
        chk(mod_sel_o == s0, "R9", mod_sel_o, s0);
      end
      @(posedge clk); #1;
      en = 1'b1;
      tag = "R9";
      go(10);
    end

    // R7 reset in mid-run, first cycle is N
    n_r = 16'd4; k_r = 6'd63;
    do_reset();
    tag = "R7";
    go(6);

    repeat (3) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule